// File: doc/BRIEF.md
# Text Cursor Blink Generator

This block produces the cursor output of a character CRT controller. The raster and address logic elsewhere in the controller feeds it five things: the current scanline within the character row, the refresh address, display enable, a pulse at each line start and a pulse each time the vertical displayed region ends. The block combines these with the cursor start register, the cursor end scanline and the cursor address.

The block keeps a 5-bit field counter that advances once per field. Bits of this counter set the blink rate. A 2-bit blink mode sits in the upper bits of the cursor start register. A build-time parameter chooses how that mode is read: a native encoding, an encoding in the style of monochrome display adapters, or no cursor at all.

The blink mask is a register. It is recomputed only when the cursor start register is written or when the field counter advances. The cursor-line decision is sampled once per line, at the line-start pulse.

Top module: `cursor_blink_gen`

## Requirements
- R1: The field counter starts at 0 after reset. It advances by one on each cycle with `field_end` high and wraps from 31 to 0. Its value is seen only through the blink behaviour.
- R2: Native encoding, mode 2'b00 (bits 6:5 of `cur_start`): the mask is on in every field.
- R3: Native encoding, mode 2'b01: the mask is off.
- R4: Native encoding, mode 2'b10: the mask equals bit 3 of the field counter. Mode 2'b11: the mask equals bit 4 of the field counter.
- R5: Alternate (`ENC_MDA`) encoding. Mode 2'b00: the mask equals field counter bit 3. Mode 2'b01: off. Mode 2'b10: always on. Mode 2'b11: on only when field counter bits 3:2 are both 0.
- R6: The mask is recomputed only in a cycle where `cur_start_we` or `field_end` is high. It uses the mode on `cur_start` and the counter value after any advance in that cycle. A change of `cur_start[6:5]` without either pulse has no effect on `cursor_out`.
- R7: At each `line_start` pulse the cursor-line flag is loaded with (`cur_start[4:0]` <= `line_in` <= `cur_end`). Between pulses it holds, whatever `line_in` does. If start is greater than end, the flag never sets.
- R8: `cursor_out` is high exactly when all four terms hold: the mask is on, the cursor-line flag is set, `refresh_addr` equals `cur_addr`, and `disp_en` is high. The output is combinational from these terms.
- R9: Reset (`rst_n` low) clears the field counter, the mask and the cursor-line flag, so `cursor_out` is low.
- R10: With `ENC` set to `ENC_NONE`, `cursor_out` is always low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 5 | Current scanline within the character row |
| refresh_addr | input | 14 | Current refresh (memory) address |
| disp_en | input | 1 | Display enable |
| line_start | input | 1 | One-cycle pulse at the start of each line |
| field_end | input | 1 | One-cycle pulse when the vertical displayed region ends |
| cur_start_we | input | 1 | Write strobe of the cursor start register |
| cur_start | input | 7 | Cursor start register: scanline in 4:0, blink mode in 6:5 |
| cur_end | input | 5 | Cursor end scanline |
| cur_addr | input | 14 | Cursor address |
| cursor_out | output | 1 | Cursor output |

## Verification
Three instances are driven in parallel with the same stimulus, one per encoding. For each blink mode, the field counter is stepped through two full wraps after the mode write. This separates steady, off, bit-3, bit-4 and short-on patterns, and it exposes a wrong counter bit or a mask update taken one field late. A scanline sweep over all 32 values against a narrow window checks both inclusive edges of the cursor-line range and the case where start is greater than end. Changes made between strobes, to the mode and to the scanline, show that the mask and the flag are sampled only at their own events. Single-term deselects of the address and display enable confirm the four-way AND.

// File: rtl/cursor_blink_pkg.sv
package cursor_blink_pkg;
  typedef enum logic [1:0] {ENC_NONE = 2'd0, ENC_NATIVE = 2'd1, ENC_MDA = 2'd2} enc_e;

  // Mask value for a blink mode and field count under a given encoding.
  function automatic logic blink_on(enc_e enc, logic [1:0] mode, logic [4:0] fcnt);
    logic r;
    r = 1'b0;
    case (enc)
      ENC_NATIVE: begin
        case (mode)
          2'b00: r = 1'b1;
          2'b01: r = 1'b0;
          2'b10: r = fcnt[3];
          default: r = fcnt[4];
        endcase
      end
      ENC_MDA: begin
        case (mode)
          2'b00: r = fcnt[3];
          2'b01: r = 1'b0;
          2'b10: r = 1'b1;
          default: r = (fcnt[3:2] == 2'b00);
        endcase
      end
      default: r = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/cb_field_counter.sv
module cb_field_counter #(
  parameter int FCNT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  output logic [FCNT_W-1:0] fcnt,
  output logic [FCNT_W-1:0] fcnt_next
);
  assign fcnt_next = advance ? fcnt + 1'b1 : fcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) fcnt <= '0;
    else        fcnt <= fcnt_next;
  end

  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> fcnt == $past(fcnt) + 1'b1);
  p_count_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(fcnt));
endmodule

// File: rtl/cb_blink_mask.sv
module cb_blink_mask
  import cursor_blink_pkg::*;
#(
  parameter enc_e ENC    = ENC_NATIVE,
  parameter int   FCNT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic              advance,
  input  logic [1:0]        mode,
  input  logic [FCNT_W-1:0] fcnt_next,
  output logic              mask
);
  logic recompute;
  assign recompute = mode_we | advance;

  always_ff @(posedge clk) begin
    if (!rst_n)         mask <= 1'b0;
    else if (recompute) mask <= blink_on(ENC, mode, fcnt_next[4:0]);
  end

  p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !recompute |=> $stable(mask));
  generate
    if (ENC == ENC_NATIVE) begin : g_nat_chk
      p_native_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_we && mode == 2'b00) |=> mask);
      p_native_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (recompute && mode == 2'b01) |=> !mask);
    end else if (ENC == ENC_MDA) begin : g_mda_chk
      p_mda_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (recompute && mode == 2'b10) |=> mask);
    end else begin : g_none_chk
      p_none_low_r10: assert property (@(posedge clk) disable iff (!rst_n) !mask);
    end
  endgenerate
endmodule

// File: rtl/cb_line_window.sv
module cb_line_window #(
  parameter int LINE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic [LINE_W-1:0] line_in,
  input  logic [LINE_W-1:0] first_line,
  input  logic [LINE_W-1:0] last_line,
  output logic              on_line
);
  logic in_window;
  assign in_window = (line_in >= first_line) && (line_in <= last_line);

  always_ff @(posedge clk) begin
    if (!rst_n)          on_line <= 1'b0;
    else if (line_start) on_line <= in_window;
  end

  p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> $stable(on_line));
  p_flag_inverted_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && first_line > last_line) |=> !on_line);
endmodule

// File: rtl/cursor_blink_gen.sv
module cursor_blink_gen
  import cursor_blink_pkg::*;
#(
  parameter enc_e ENC    = ENC_NATIVE,
  parameter int   ADDR_W = 14,
  parameter int   LINE_W = 5,
  parameter int   FCNT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] line_in,
  input  logic [ADDR_W-1:0] refresh_addr,
  input  logic              disp_en,
  input  logic              line_start,
  input  logic              field_end,
  input  logic              cur_start_we,
  input  logic [LINE_W+1:0] cur_start,
  input  logic [LINE_W-1:0] cur_end,
  input  logic [ADDR_W-1:0] cur_addr,
  output logic              cursor_out
);
  localparam int MODE_LSB = LINE_W;

  logic [FCNT_W-1:0] fcnt, fcnt_next;
  logic              mask, on_line, addr_hit;

  cb_field_counter #(.FCNT_W(FCNT_W)) u_fcnt (
    .clk(clk), .rst_n(rst_n), .advance(field_end),
    .fcnt(fcnt), .fcnt_next(fcnt_next));

  cb_blink_mask #(.ENC(ENC), .FCNT_W(FCNT_W)) u_mask (
    .clk(clk), .rst_n(rst_n), .mode_we(cur_start_we), .advance(field_end),
    .mode(cur_start[MODE_LSB+1:MODE_LSB]), .fcnt_next(fcnt_next), .mask(mask));

  cb_line_window #(.LINE_W(LINE_W)) u_win (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_in(line_in),
    .first_line(cur_start[LINE_W-1:0]), .last_line(cur_end), .on_line(on_line));

  assign addr_hit = (refresh_addr == cur_addr);

  generate
    if (ENC == ENC_NONE) begin : g_none
      assign cursor_out = 1'b0;
    end else begin : g_live
      assign cursor_out = mask & on_line & addr_hit & disp_en;
    end
  endgenerate

  p_out_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cursor_out |-> (disp_en && on_line && mask));
  p_reset_clears_r9: assert property (@(posedge clk)
    !rst_n |=> !cursor_out);
endmodule

// File: tb/cursor_blink_gen_bench.sv
module cursor_blink_gen_bench;
  import cursor_blink_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [4:0]  line_in = '0;
  logic [13:0] refresh_addr = 14'h1234;
  logic        disp_en = 1'b1;
  logic        line_start = 1'b0;
  logic        field_end = 1'b0;
  logic        cur_start_we = 1'b0;
  logic [6:0]  cur_start = '0;
  logic [4:0]  cur_end = 5'd31;
  logic [13:0] cur_addr = 14'h1234;
  logic        out_nat, out_mda, out_none;

  cursor_blink_gen #(.ENC(ENC_NATIVE)) u_cursor_blink_gen (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .refresh_addr(refresh_addr),
    .disp_en(disp_en), .line_start(line_start), .field_end(field_end),
    .cur_start_we(cur_start_we), .cur_start(cur_start), .cur_end(cur_end),
    .cur_addr(cur_addr), .cursor_out(out_nat));
  cursor_blink_gen #(.ENC(ENC_MDA)) u_cursor_blink_gen_mda (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .refresh_addr(refresh_addr),
    .disp_en(disp_en), .line_start(line_start), .field_end(field_end),
    .cur_start_we(cur_start_we), .cur_start(cur_start), .cur_end(cur_end),
    .cur_addr(cur_addr), .cursor_out(out_mda));
  cursor_blink_gen #(.ENC(ENC_NONE)) u_cursor_blink_gen_none (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .refresh_addr(refresh_addr),
    .disp_en(disp_en), .line_start(line_start), .field_end(field_end),
    .cur_start_we(cur_start_we), .cur_start(cur_start), .cur_end(cur_end),
    .cur_addr(cur_addr), .cursor_out(out_none));

  int checks = 0;
  int fails  = 0;
  int fields = 0;
  bit done   = 0;

  function automatic bit exp_native(int mode, int f);
    if (mode == 0) return 1;
    if (mode == 1) return 0;
    if (mode == 2) return ((f / 8) % 2) == 1;
    return ((f / 16) % 2) == 1;
  endfunction

  function automatic bit exp_mda(int mode, int f);
    if (mode == 0) return ((f / 8) % 2) == 1;
    if (mode == 1) return 0;
    if (mode == 2) return 1;
    return (f % 16) < 4;
  endfunction

  task automatic check(bit en, bit em, string req);
    checks++;
    if (out_nat !== en) begin
      fails++;
      $display("FAIL %s native: got %b expected %b", req, out_nat, en);
    end
    checks++;
    if (out_mda !== em) begin
      fails++;
      $display("FAIL %s alternate: got %b expected %b", req, out_mda, em);
    end
    checks++;
    if (out_none !== 1'b0) begin
      fails++;
      $display("FAIL R10 none: got %b expected 0", out_none);
    end
  endtask

  task automatic pulse_we();
    cur_start_we = 1'b1; @(negedge clk); cur_start_we = 1'b0;
  endtask
  task automatic pulse_field();
    field_end = 1'b1; @(negedge clk); field_end = 1'b0;
    fields = (fields + 1) % 32;
  endtask
  task automatic pulse_line();
    line_start = 1'b1; @(negedge clk); line_start = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: all outer terms are asserted, yet reset leaves the output low
    check(0, 0, "R9");
    rst_n = 1'b1;
    @(negedge clk);
    check(0, 0, "R9");

    // Line flag on for the blink sweeps
    line_in = 5'd5; cur_start = 7'h00; cur_end = 5'd31;
    pulse_line();

    // R1..R5: each mode over two full counter wraps
    for (int m = 0; m < 4; m++) begin
      cur_start = {m[1:0], 5'd0};
      pulse_we();
      check(exp_native(m, fields), exp_mda(m, fields), "R2-mode write");
      for (int k = 0; k < 64; k++) begin
        pulse_field();
        if (m == 0)      check(exp_native(m, fields), exp_mda(m, fields), "R2/R5 R1");
        else if (m == 1) check(exp_native(m, fields), exp_mda(m, fields), "R3/R5 R1");
        else             check(exp_native(m, fields), exp_mda(m, fields), "R4/R5 R1");
      end
    end

    // R6: mode change without a strobe has no effect
    cur_start = 7'b01_00000; pulse_we();
    check(0, 0, "R6 off");
    cur_start = 7'b10_00000;
    repeat (3) @(negedge clk);
    check(0, 0, "R6 unstrobed");
    pulse_we();
    check(exp_native(2, fields), 1, "R6 strobed");

    // R7: window 8..12, steady native mode
    cur_start = 7'b00_01000; cur_end = 5'd12; pulse_we();
    for (int ln = 0; ln < 32; ln++) begin
      line_in = ln[4:0];
      pulse_line();
      check(ln >= 8 && ln <= 12, (ln >= 8 && ln <= 12) && exp_mda(0, fields), "R7 window");
    end
    line_in = 5'd0; pulse_line();
    line_in = 5'd10;
    repeat (2) @(negedge clk);
    check(0, 0, "R7 between starts");
    cur_start = 7'b00_01100; cur_end = 5'd8;
    line_in = 5'd10; pulse_line();
    check(0, 0, "R7 inverted");

    // R8: deselect one term at a time
    cur_start = 7'b10_00000; cur_end = 5'd31; pulse_we(); pulse_line();
    check(exp_native(2, fields), 1, "R8 all terms");
    disp_en = 1'b0; #1; check(0, 0, "R8 disp_en");
    disp_en = 1'b1;
    for (int b = 0; b < 14; b++) begin
      refresh_addr = cur_addr ^ (14'd1 << b);
      #1; check(0, 0, "R8 address");
    end
    refresh_addr = cur_addr;
    #1; check(exp_native(2, fields), 1, "R8 restored");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule